// File: doc/BRIEF.md
# Gated Time Pulse Accumulator

This block measures how long an external gate signal stays at a chosen level. A free-running prescaler divides the timer clock by 64 whenever the timer is enabled. In gated time mode, each divided tick that arrives while the synchronised gate sits at its active level adds one to a 16-bit counter. When the active window ends, an input flag is raised. Software picks which level is active, can load or read the counter at any time, and clears the flags with one-cycle strobes. Each flag raises an interrupt only when its enable bit is set.

Clearing the mode bit selects the other mode, event counting. In that mode the prescaler is not used. The counter adds one for each synchronised gate edge of the direction that the polarity bit selects, and each counted edge also sets the input flag. In both modes, when the counter wraps from all ones to zero it sets a separate overflow flag.

Top module: `gpa_top`

## Requirements
- R1: After reset the counter reads 0, both flags are 0 and both interrupt outputs are 0.
- R2: In gated mode (`mode_gated`=1) with the timer enabled, the counter adds one on every 64th enabled cycle, counted from the cycle the timer was last enabled, provided the synchronised gate is at its active level in that cycle. `pol_high`=1 makes high the active level; `pol_high`=0 makes low the active level.
- R3: While `tmr_en` is 0 no divided ticks occur and the gated-mode counter holds its value. When `tmr_en` is 0 the prescaler returns to zero, so a new 64-cycle period starts when the timer is enabled again.
- R4: In gated mode, ticks that arrive while the gate is at its inactive level are not counted.
- R5: The gate pin passes through a two-flip-flop synchroniser. In gated mode, the trailing edge of the active level sets `in_flag` at the third rising clock edge after the pin changes.
- R6: In event mode (`mode_gated`=0), the counter adds one and `in_flag` is set for each synchronised rising edge of the gate (`pol_high`=1) or falling edge (`pol_high`=0). In this mode the prescaler and `tmr_en` are not used.
- R7: A wrap of the counter from 0xFFFF to 0x0000 caused by counting sets `ovf_flag`.
- R8: A `cnt_wr` pulse loads `cnt_wdata` into the counter at the next edge. The load takes priority over an increment in the same cycle and never sets `ovf_flag`.
- R9: A 1 on `clr_in_flag` or `clr_ovf_flag` clears the matching flag. A set condition in the same cycle as the clear wins, and a flag stays set until it is cleared.
- R10: `irq_in` is high only while both `in_flag` and `in_ie` are high. `irq_ovf` is high only while both `ovf_flag` and `ovf_ie` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which is also the timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_en | input | 1 | Timer enable; drives the divide-by-64 prescaler |
| gate_pin | input | 1 | Asynchronous gate / event input |
| mode_gated | input | 1 | 1 = gated time mode, 0 = event counting |
| pol_high | input | 1 | Gated: 1 = high active. Event: 1 = rising edges |
| in_ie | input | 1 | Input-flag interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | 16 | Counter load value |
| clr_in_flag | input | 1 | Write-one clear strobe for the input flag |
| clr_ovf_flag | input | 1 | Write-one clear strobe for the overflow flag |
| cnt_rd | output | 16 | Current counter value |
| in_flag | output | 1 | Input flag (end of the gate window, or a counted edge) |
| ovf_flag | output | 1 | Counter overflow flag |
| irq_in | output | 1 | Input interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach from the ports is a collision inside one cycle. Examples are a divided tick that lands in the same cycle as a counter load, or a trailing gate edge that lands while a clear strobe is held. A tick occurs only once every 64 cycles, so the stimulus holds `cnt_wr` high for a whole prescaler period; one of those loads must then meet a tick. The clear strobe is held high across a programmed gate edge, and the flag is sampled at the exact edge at which the set wins. To reach a wrap without counting 65536 ticks, the counter is first loaded to just below 0xFFFF.

// File: rtl/gpa_pkg.sv
package gpa_pkg;
    localparam int unsigned GPA_CNT_W   = 16;
    localparam int unsigned GPA_DIV     = 64;
    localparam int unsigned GPA_SYNC_N  = 2;

    typedef enum logic {
        ACC_MODE_EVENT = 1'b0,
        ACC_MODE_GATED = 1'b1
    } acc_mode_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } gate_info_t;
endpackage

// File: rtl/gpa_prescaler.sv
module gpa_prescaler #(
    parameter int unsigned DIV = gpa_pkg::GPA_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tick
);
    localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } psc_t;

    psc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = enable && (st_q.cnt == LAST);
        if (!enable) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/gpa_gate_sync.sv
module gpa_gate_sync #(
    parameter int unsigned STAGES = gpa_pkg::GPA_SYNC_N
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pin,
    output gpa_pkg::gate_info_t info
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;
    logic  lvl;

    generate
        if (STAGES == 1) begin : g_single
            always_comb st_d.chain = pin;
        end else begin : g_multi
            always_comb st_d.chain = {st_q.chain[STAGES-2:0], pin};
        end
    endgenerate

    assign lvl = st_q.chain[STAGES-1];

    always_comb begin
        st_d.prev  = lvl;
        info.level = lvl;
        info.rise  = lvl && !st_q.prev;
        info.fall  = !lvl && st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/gpa_event_sel.sv
module gpa_event_sel (
    input  gpa_pkg::gate_info_t info,
    input  logic                mode_gated,
    input  logic                pol_high,
    input  logic                tick,
    output logic                inc,
    output logic                in_set
);
    logic active;
    logic trailing;
    logic sel_edge;

    always_comb begin
        active   = pol_high ? info.level : !info.level;
        trailing = pol_high ? info.fall : info.rise;
        sel_edge = pol_high ? info.rise : info.fall;
        if (gpa_pkg::acc_mode_e'(mode_gated) == gpa_pkg::ACC_MODE_GATED) begin
            inc    = tick && active;
            in_set = trailing;
        end else begin
            inc    = sel_edge;
            in_set = sel_edge;
        end
    end
endmodule

// File: rtl/gpa_top.sv
module gpa_top #(
    parameter int unsigned CNT_W  = gpa_pkg::GPA_CNT_W,
    parameter int unsigned DIV    = gpa_pkg::GPA_DIV,
    parameter int unsigned STAGES = gpa_pkg::GPA_SYNC_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_en,
    input  logic             gate_pin,
    input  logic             mode_gated,
    input  logic             pol_high,
    input  logic             in_ie,
    input  logic             ovf_ie,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             clr_in_flag,
    input  logic             clr_ovf_flag,
    output logic [CNT_W-1:0] cnt_rd,
    output logic             in_flag,
    output logic             ovf_flag,
    output logic             irq_in,
    output logic             irq_ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             in_flag;
        logic             ovf_flag;
    } acc_t;

    acc_t                st_d, st_q;
    logic                tick;
    logic                inc;
    logic                in_set;
    logic                ovf_set;
    gpa_pkg::gate_info_t ginfo;

    gpa_prescaler #(.DIV(DIV)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (tmr_en),
        .tick   (tick)
    );

    gpa_gate_sync #(.STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (gate_pin),
        .info  (ginfo)
    );

    gpa_event_sel u_sel (
        .info       (ginfo),
        .mode_gated (mode_gated),
        .pol_high   (pol_high),
        .tick       (tick),
        .inc        (inc),
        .in_set     (in_set)
    );

    always_comb begin
        st_d    = st_q;
        ovf_set = 1'b0;
        if (cnt_wr) begin
            st_d.cnt = cnt_wdata;
        end else if (inc) begin
            st_d.cnt = st_q.cnt + 1'b1;
            ovf_set  = (st_q.cnt == CNT_MAX);
        end
        if (in_set) begin
            st_d.in_flag = 1'b1;
        end else if (clr_in_flag) begin
            st_d.in_flag = 1'b0;
        end
        if (ovf_set) begin
            st_d.ovf_flag = 1'b1;
        end else if (clr_ovf_flag) begin
            st_d.ovf_flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_rd   = st_q.cnt;
    assign in_flag  = st_q.in_flag;
    assign ovf_flag = st_q.ovf_flag;
    assign irq_in   = st_q.in_flag && in_ie;
    assign irq_ovf  = st_q.ovf_flag && ovf_ie;
endmodule

// File: rtl/gpa_checker.sv
module gpa_checker #(
    parameter int unsigned CNT_W = gpa_pkg::GPA_CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tmr_en,
    input logic             mode_gated,
    input logic             in_ie,
    input logic             ovf_ie,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic             clr_in_flag,
    input logic             clr_ovf_flag,
    input logic [CNT_W-1:0] cnt_rd,
    input logic             in_flag,
    input logic             ovf_flag,
    input logic             irq_in,
    input logic             irq_ovf
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (cnt_rd == $past(cnt_rd)) || (cnt_rd == CNT_W'($past(cnt_rd) + 1'b1))); // R2
    AST_CNT_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_gated && !tmr_en && !cnt_wr) |=> (cnt_rd == $past(cnt_rd))); // R3
    AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && (cnt_rd == '1)) |=> ((cnt_rd != '0) || ovf_flag)); // R7
    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_rd == $past(cnt_wdata))); // R8
    AST_IN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_flag && !clr_in_flag) |=> in_flag); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_ovf_flag) |=> ovf_flag); // R9
    AST_IRQ_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ie || !in_flag) |-> !irq_in); // R10
    AST_IRQ_OVF_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_ie || !ovf_flag) |-> !irq_ovf); // R10
endmodule

bind gpa_top gpa_checker #(.CNT_W(CNT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tmr_en       (tmr_en),
    .mode_gated   (mode_gated),
    .in_ie        (in_ie),
    .ovf_ie       (ovf_ie),
    .cnt_wr       (cnt_wr),
    .cnt_wdata    (cnt_wdata),
    .clr_in_flag  (clr_in_flag),
    .clr_ovf_flag (clr_ovf_flag),
    .cnt_rd       (cnt_rd),
    .in_flag      (in_flag),
    .ovf_flag     (ovf_flag),
    .irq_in       (irq_in),
    .irq_ovf      (irq_ovf)
);

// File: tb/gpa_top_tb_top.sv
`timescale 1ns/1ps
module gpa_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_en = 1'b0, gate_pin = 1'b0, mode_gated = 1'b0, pol_high = 1'b0;
    logic        in_ie = 1'b0, ovf_ie = 1'b0, cnt_wr = 1'b0;
    logic [15:0] cnt_wdata = '0;
    logic        clr_in_flag = 1'b0, clr_ovf_flag = 1'b0;
    logic [15:0] cnt_rd;
    logic        in_flag, ovf_flag, irq_in, irq_ovf;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpa_top dut_i (
        .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .gate_pin(gate_pin),
        .mode_gated(mode_gated), .pol_high(pol_high), .in_ie(in_ie), .ovf_ie(ovf_ie),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .clr_in_flag(clr_in_flag),
        .clr_ovf_flag(clr_ovf_flag), .cnt_rd(cnt_rd), .in_flag(in_flag),
        .ovf_flag(ovf_flag), .irq_in(irq_in), .irq_ovf(irq_ovf)
    );

    // behavioural reference model
    int m_psc = 0, m_cnt = 0, m_prev = 0;
    bit m_fin = 0, m_fovf = 0;
    int m_pipe[$] = '{0, 0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_psc = 0; m_cnt = 0; m_prev = 0; m_fin = 0; m_fovf = 0;
            m_pipe = '{0, 0};
        end else begin
            int  g;
            bit  tk, act, trail, edg, inc, sin, sovf;
            g     = m_pipe[$];
            tk    = tmr_en && (m_psc == 63);
            act   = pol_high ? (g == 1) : (g == 0);
            trail = pol_high ? (g == 0 && m_prev == 1) : (g == 1 && m_prev == 0);
            edg   = pol_high ? (g == 1 && m_prev == 0) : (g == 0 && m_prev == 1);
            inc   = mode_gated ? (tk && act) : edg;
            sin   = mode_gated ? trail : edg;
            sovf  = 0;
            if (cnt_wr) m_cnt = cnt_wdata;
            else if (inc) begin
                if (m_cnt == 65535) sovf = 1;
                m_cnt = (m_cnt + 1) % 65536;
            end
            if (sin) m_fin = 1; else if (clr_in_flag) m_fin = 0;
            if (sovf) m_fovf = 1; else if (clr_ovf_flag) m_fovf = 0;
            m_psc  = tmr_en ? ((m_psc + 1) % 64) : 0;
            m_prev = g;
            void'(m_pipe.pop_back());
            m_pipe.push_front(int'(gate_pin));
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            check(cnt_rd == m_cnt[15:0], "R2", "cnt", cnt_rd, m_cnt);
            check(in_flag == m_fin, "R5", "in_flag", in_flag, m_fin);
            check(ovf_flag == m_fovf, "R7", "ovf_flag", ovf_flag, m_fovf);
            check(irq_in == (m_fin && in_ie), "R10", "irq_in", irq_in, m_fin && in_ie);
            check(irq_ovf == (m_fovf && ovf_ie), "R10", "irq_ovf", irq_ovf, m_fovf && ovf_ie);
        end
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int base;
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cnt_rd == 0 && !in_flag && !ovf_flag && !irq_in && !irq_ovf, "R1", "reset", cnt_rd, 0);

        // R2 high-active gated counting
        mode_gated = 1; pol_high = 1; in_ie = 1; gate_pin = 1;
        wait_n(4);
        base = cnt_rd; tmr_en = 1;
        wait_n(256);
        check(cnt_rd == base + 4, "R2", "high-active ticks", cnt_rd, base + 4);
        // R5 trailing edge
        gate_pin = 0;
        wait_n(2);
        check(!in_flag, "R5", "flag before third edge", in_flag, 0);
        @(negedge clk);
        check(in_flag && irq_in, "R5", "flag at third edge", in_flag, 1);
        clr_in_flag = 1; @(negedge clk); clr_in_flag = 0;
        check(!in_flag, "R9", "clear", in_flag, 0);
        // R4 inactive level
        base = cnt_rd;
        wait_n(300);
        check(cnt_rd == base, "R4", "inactive no count", cnt_rd, base);
        // R3 timer disabled
        gate_pin = 1; wait_n(4); tmr_en = 0; wait_n(2);
        base = cnt_rd;
        wait_n(300);
        check(cnt_rd == base, "R3", "timer off hold", cnt_rd, base);
        tmr_en = 1; wait_n(64);
        check(cnt_rd == base + 1, "R3", "restart period", cnt_rd, base + 1);
        // R2 low-active
        pol_high = 0; gate_pin = 0; tmr_en = 0; wait_n(4);
        clr_in_flag = 1; @(negedge clk); clr_in_flag = 0;
        base = cnt_rd; tmr_en = 1;
        wait_n(192);
        check(cnt_rd == base + 3, "R2", "low-active ticks", cnt_rd, base + 3);
        // R9 set beats clear
        clr_in_flag = 1; gate_pin = 1;
        wait_n(3);
        check(in_flag, "R9", "set wins over clear", in_flag, 1);
        @(negedge clk);
        check(!in_flag, "R9", "clear after set", in_flag, 0);
        clr_in_flag = 0;

        // R6 event mode
        mode_gated = 0; pol_high = 1; tmr_en = 0; gate_pin = 0; wait_n(4);
        base = cnt_rd;
        for (int k = 0; k < 5; k++) begin
            gate_pin = 1; wait_n(4); gate_pin = 0; wait_n(4);
        end
        check(cnt_rd == base + 5, "R6", "rising edges", cnt_rd, base + 5);
        pol_high = 0; wait_n(4); base = cnt_rd;
        for (int k = 0; k < 3; k++) begin
            gate_pin = 1; wait_n(3); gate_pin = 0; wait_n(3);
        end
        wait_n(3);
        check(cnt_rd == base + 3, "R6", "falling edges", cnt_rd, base + 3);

        // R8 write load
        cnt_wr = 1; cnt_wdata = 16'h1234; @(negedge clk); cnt_wr = 0;
        check(cnt_rd == 16'h1234, "R8", "load", cnt_rd, 16'h1234);

        // R7 wrap
        ovf_ie = 1; mode_gated = 1; pol_high = 1; gate_pin = 1; tmr_en = 0;
        cnt_wr = 1; cnt_wdata = 16'hFFFE; @(negedge clk); cnt_wr = 0;
        wait_n(3); tmr_en = 1;
        wait_n(128);
        check(cnt_rd == 0 && ovf_flag && irq_ovf, "R7", "wrap", cnt_rd, 0);
        clr_ovf_flag = 1; @(negedge clk); clr_ovf_flag = 0;
        check(!ovf_flag, "R9", "ovf clear", ovf_flag, 0);

        // R8 load over concurrent ticks, load of all ones never flags overflow
        cnt_wr = 1; cnt_wdata = 16'hFFFF;
        wait_n(70);
        cnt_wr = 0;
        check(cnt_rd == 16'hFFFF && !ovf_flag, "R8", "load beats tick", cnt_rd, 16'hFFFF);
        ovf_ie = 0; in_ie = 0;
        wait_n(70);
        check(!irq_ovf && !irq_in, "R10", "masked irqs", irq_ovf, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule